// File: doc/BRIEF.md
# Network Interrupt Moderation Controller

This block gathers interrupt causes for a network interface and decides when the CPU interrupt line goes high. It keeps a seven-bit cause register and a seven-bit mask register. It enforces a minimum spacing between successive assertions, measured from the last successful post. It also runs three delay timers that turn packet events into causes: a receive per-packet timer that restarts on every packet, a receive absolute timer that is armed once and then runs to completion, and a transmit timer. A free-running time input supplies the current cycle count. Every deadline is held as an absolute count and compared by wrap-safe subtraction.

A controller FSM holds two things: the interrupt line and whether the throttle timer is armed. It has four states. `ST_IDLE` means the line is low and no timer is armed. `ST_HOLD` means the line is low and the throttle timer is armed. `ST_RAISED` means the line is high and no timer is armed. `ST_RAISED_HOLD` means the line is high and the throttle timer is armed.

The transitions are as follows:
- A successful post moves the FSM from any state to `ST_RAISED`.
- A throttled request moves `ST_IDLE` to `ST_HOLD`, and `ST_RAISED` to `ST_RAISED_HOLD`.
- When the throttle deadline arrives in `ST_HOLD` or `ST_RAISED_HOLD`, the FSM makes a post attempt. If the attempt fails, the FSM falls back to `ST_IDLE`, or to `ST_RAISED` if the line was high.
- A cause read takes the FSM from `ST_RAISED` to `ST_IDLE`, and from `ST_RAISED_HOLD` to `ST_HOLD`.
- A mask write that leaves no unmasked cause moves the FSM from any state to `ST_IDLE`.

Within one cycle, events are applied in a fixed order:
1. the cause read,
2. timer expiries, packet events and external requests,
3. the throttle expiry,
4. the mask write,
5. at most one post attempt.

Top module: `intr_moderator`

## Requirements
- R1: After reset, `irq` is low, `cause_q` is zero, `post_cnt` is zero, the mask is zero and no timer is armed.
- R2: Raised cause bits are ORed into the cause register. A request that raises only bits already pending has no further effect, unless `req_now` is set with `req_valid`.
- R3: `itv_cfg` counts units of UNIT_CYC cycles. When `itv_cfg` is zero, an accepted request makes a post attempt in the same cycle.
- R4: An accepted request posts at once when it is immediate, or when `time_now` is not earlier than the last post time plus the interval. Otherwise it arms the throttle timer for the last post time plus the interval, unless the timer is already armed. When the throttle deadline is reached, a post attempt is made.
- R5: Every post attempt increments `post_cnt`. An attempt succeeds only if some cause bit is unmasked (cause AND mask nonzero); a failed attempt leaves `irq` unchanged.
- R6: A successful post cancels the throttle timer. If a receive timer is running, the post cancels it and sets cause bit 1. If the transmit timer is running, the post cancels it and sets cause bit 0.
- R7: A successful post sets `cause_q[7]`, drives `irq` high and records `time_now` as the last post time. `irq` always equals `cause_q[7]`.
- R8: A mask write whose new mask leaves no unmasked cause cancels the throttle timer and clears `irq` and `cause_q[7]`.
- R9: A mask write that leaves an unmasked cause makes a post attempt if `itv_cfg` is zero. Otherwise it arms the throttle timer for `time_now` plus the interval, if the timer is idle.
- R10: On `rx_done`:
  - a nonzero `pd_cfg` restarts the per-packet timer for `pd_cfg`×DLY_UNIT cycles;
  - a nonzero `ab_cfg` arms the absolute timer for `ab_cfg`×DLY_UNIT cycles, only if it is idle;
  - if both are zero, cause bit 1 is raised directly.

  When either receive timer expires, it raises cause bit 1.
- R11: On `rx_done`, if `rx_len` is less than or equal to `small_thr`, cause bit 2 is raised.
- R12: On `tx_done`, a nonzero `tx_cfg` restarts the transmit timer for `tx_cfg`×DLY_UNIT cycles, and a zero `tx_cfg` raises cause bit 0 directly. When the transmit timer expires, it raises cause bit 0.
- R13: `cause_rd` clears the cause register and the line before the same cycle's other events are applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| time_now | input | TW | Free-running cycle count |
| req_valid | input | 1 | External cause request strobe |
| req_now | input | 1 | Request bypasses throttling and pending filter |
| req_causes | input | 7 | Cause bits of the request |
| mask_wr | input | 1 | Mask update strobe |
| mask_data | input | 7 | New mask value |
| cause_rd | input | 1 | Read-to-clear strobe |
| itv_cfg | input | IW | Throttle interval in UNIT_CYC units |
| pd_cfg | input | DW | Receive per-packet delay |
| ab_cfg | input | DW | Receive absolute delay |
| tx_cfg | input | DW | Transmit delay |
| small_thr | input | LW | Small packet length threshold |
| rx_done | input | 1 | Receive completion strobe |
| rx_len | input | LW | Length of the completed packet |
| tx_done | input | 1 | Transmit completion strobe |
| irq | output | 1 | Interrupt line |
| cause_q | output | 8 | {asserted flag, cause bits} |
| post_cnt | output | NW | Post attempt counter |

## Verification
The hardest situation to reach is a successful post that lands while a receive or transmit timer is still running, so that the timer's cause is folded in and its later expiry never happens. The stimulus programs long delays, starts the timers with packet events, and then forces an immediate request before the deadline. The same approach is used with a long throttle interval, so that a throttle deadline that is already armed meets a mask write and a read. A long phase of seeded random events then crosses all of these with the same-cycle ordering. A behavioural model checks every output on every cycle.

// File: rtl/imod_pkg.sv
package imod_pkg;
    localparam int CW     = 7;
    localparam int B_TXDW = 0;
    localparam int B_RXT  = 1;
    localparam int B_SRPD = 2;

    typedef enum logic [1:0] {
        ST_IDLE        = 2'd0,
        ST_HOLD        = 2'd1,
        ST_RAISED      = 2'd2,
        ST_RAISED_HOLD = 2'd3
    } mod_state_t;
endpackage

// File: rtl/imod_dtimer.sv
module imod_dtimer #(
    parameter int TW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [TW-1:0] now,
    input  logic [TW-1:0] dur,
    input  logic          restart,
    input  logic          arm_idle,
    input  logic          cancel,
    output logic          due,
    output logic          live
);
    logic          on_q;
    logic [TW-1:0] dl_q;
    logic [TW-1:0] diff;
    logic          start;

    // wrap-safe: deadline reached when now - dl is non-negative
    assign diff  = now - dl_q;
    assign due   = on_q && !diff[TW-1];
    assign start = restart || (arm_idle && !(on_q && !due));
    assign live  = start || (on_q && !due);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            on_q <= 1'b0;
            dl_q <= '0;
        end else begin
            on_q <= live && !cancel;
            if (start) dl_q <= now + dur;
        end
    end
endmodule

// File: rtl/imod_evsrc.sv
module imod_evsrc import imod_pkg::*; #(
    parameter int DW = 16,
    parameter int LW = 16
) (
    input  logic          rx_done,
    input  logic [LW-1:0] rx_len,
    input  logic [LW-1:0] small_thr,
    input  logic [DW-1:0] pd_cfg,
    input  logic [DW-1:0] ab_cfg,
    input  logic          tx_done,
    input  logic [DW-1:0] tx_cfg,
    output logic [CW-1:0] ev_raise,
    output logic          pd_restart,
    output logic          ab_arm,
    output logic          tx_restart
);
    logic pd_nz, ab_nz, tx_nz;

    assign pd_nz      = |pd_cfg;
    assign ab_nz      = |ab_cfg;
    assign tx_nz      = |tx_cfg;
    assign pd_restart = rx_done && pd_nz;
    assign ab_arm     = rx_done && ab_nz;
    assign tx_restart = tx_done && tx_nz;

    always_comb begin
        ev_raise = '0;
        if (rx_done && !pd_nz && !ab_nz) ev_raise[B_RXT]  = 1'b1;
        if (rx_done && (rx_len <= small_thr)) ev_raise[B_SRPD] = 1'b1;
        if (tx_done && !tx_nz) ev_raise[B_TXDW] = 1'b1;
    end
endmodule

// File: rtl/intr_moderator.sv
module intr_moderator import imod_pkg::*; #(
    parameter int TW       = 32,
    parameter int IW       = 16,
    parameter int DW       = 16,
    parameter int LW       = 16,
    parameter int NW       = 16,
    parameter int UNIT_CYC = 4,
    parameter int DLY_UNIT = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [TW-1:0] time_now,
    input  logic          req_valid,
    input  logic          req_now,
    input  logic [CW-1:0] req_causes,
    input  logic          mask_wr,
    input  logic [CW-1:0] mask_data,
    input  logic          cause_rd,
    input  logic [IW-1:0] itv_cfg,
    input  logic [DW-1:0] pd_cfg,
    input  logic [DW-1:0] ab_cfg,
    input  logic [DW-1:0] tx_cfg,
    input  logic [LW-1:0] small_thr,
    input  logic          rx_done,
    input  logic [LW-1:0] rx_len,
    input  logic          tx_done,
    output logic          irq,
    output logic [CW:0]   cause_q,
    output logic [NW-1:0] post_cnt
);
    localparam logic [TW-1:0] IU = TW'(UNIT_CYC);
    localparam logic [TW-1:0] DU = TW'(DLY_UNIT);

    mod_state_t    st_q, st_d;
    logic [CW-1:0] cause_lo_q, c0, c1, c2, raise, ev_raise, mask_q, mask_eff;
    logic [TW-1:0] last_q, th_dl_q, itv_span, gap_diff, th_diff, th_base;
    logic [NW-1:0] cnt_q;
    logic          th_on, th_due, line0, imm, trigger, gap_ok, itv_zero;
    logic          trig_post, trig_arm, any_unm, mask_kill, mask_post, mask_arm;
    logic          post_try, post_ok, th_arm, th_nx, line_nx;
    logic          pd_restart, ab_arm, tx_restart;
    logic          pd_due, ab_due, tx_due, pd_live, ab_live, tx_live;

    imod_evsrc #(.DW(DW), .LW(LW)) u_evsrc (
        .rx_done(rx_done), .rx_len(rx_len), .small_thr(small_thr),
        .pd_cfg(pd_cfg), .ab_cfg(ab_cfg), .tx_done(tx_done), .tx_cfg(tx_cfg),
        .ev_raise(ev_raise), .pd_restart(pd_restart), .ab_arm(ab_arm),
        .tx_restart(tx_restart)
    );

    imod_dtimer #(.TW(TW)) u_pd (
        .clk(clk), .rst_n(rst_n), .now(time_now), .dur(TW'(pd_cfg) * DU),
        .restart(pd_restart), .arm_idle(1'b0), .cancel(post_ok),
        .due(pd_due), .live(pd_live)
    );
    imod_dtimer #(.TW(TW)) u_ab (
        .clk(clk), .rst_n(rst_n), .now(time_now), .dur(TW'(ab_cfg) * DU),
        .restart(1'b0), .arm_idle(ab_arm), .cancel(post_ok),
        .due(ab_due), .live(ab_live)
    );
    imod_dtimer #(.TW(TW)) u_tx (
        .clk(clk), .rst_n(rst_n), .now(time_now), .dur(TW'(tx_cfg) * DU),
        .restart(tx_restart), .arm_idle(1'b0), .cancel(post_ok),
        .due(tx_due), .live(tx_live)
    );

    // output process: decode line and throttle flag from the state
    always_comb begin
        unique case (st_q)
            ST_IDLE:        begin irq = 1'b0; th_on = 1'b0; end
            ST_HOLD:        begin irq = 1'b0; th_on = 1'b1; end
            ST_RAISED:      begin irq = 1'b1; th_on = 1'b0; end
            ST_RAISED_HOLD: begin irq = 1'b1; th_on = 1'b1; end
            default:        begin irq = 1'b0; th_on = 1'b0; end
        endcase
        cause_q  = {irq, cause_lo_q};
        post_cnt = cnt_q;
    end

    assign itv_span = TW'(itv_cfg) * IU;
    assign itv_zero = (itv_cfg == '0);
    assign th_diff  = time_now - th_dl_q;
    assign th_due   = th_on && !th_diff[TW-1];
    assign gap_diff = time_now - (last_q + itv_span);
    assign gap_ok   = !gap_diff[TW-1];
    assign mask_eff = mask_wr ? mask_data : mask_q;

    // ordered event evaluation for one cycle
    always_comb begin
        c0    = cause_rd ? '0 : cause_lo_q;
        line0 = cause_rd ? 1'b0 : irq;
        raise = ev_raise;
        if (pd_due || ab_due) raise[B_RXT]  = 1'b1;
        if (tx_due)           raise[B_TXDW] = 1'b1;
        if (req_valid)        raise = raise | req_causes;
        imm       = req_valid && req_now;
        trigger   = (raise != '0) && (imm || ((raise & ~c0) != '0));
        c1        = c0 | raise;
        trig_post = trigger && (itv_zero || imm || gap_ok);
        trig_arm  = trigger && !(itv_zero || imm || gap_ok);
        any_unm   = (c1 & mask_eff) != '0;
        mask_kill = mask_wr && !any_unm;
        mask_post = mask_wr && any_unm && itv_zero;
        mask_arm  = mask_wr && any_unm && !itv_zero;
        post_try  = trig_post || th_due || mask_post;
        post_ok   = post_try && any_unm;
        th_arm    = (trig_arm || mask_arm) && !(th_on && !th_due);
        th_base   = trig_arm ? last_q : time_now;
        th_nx     = !(post_ok || mask_kill) && (th_arm || (th_on && !th_due));
        c2        = c1;
        if (post_ok && (pd_live || ab_live)) c2[B_RXT]  = 1'b1;
        if (post_ok && tx_live)              c2[B_TXDW] = 1'b1;
        line_nx   = post_ok ? 1'b1 : (mask_kill ? 1'b0 : line0);
        unique case ({line_nx, th_nx})
            2'b00:   st_d = ST_IDLE;
            2'b01:   st_d = ST_HOLD;
            2'b10:   st_d = ST_RAISED;
            default: st_d = ST_RAISED_HOLD;
        endcase
    end

    // state register process
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cause_lo_q <= '0;
            mask_q     <= '0;
            last_q     <= '0;
            th_dl_q    <= '0;
            cnt_q      <= '0;
        end else begin
            cause_lo_q <= c2;
            mask_q     <= mask_eff;
            if (post_ok)  last_q  <= time_now;
            if (th_arm)   th_dl_q <= th_base + itv_span;
            if (post_try) cnt_q   <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/imod_checker.sv
module imod_checker #(
    parameter int NW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          irq,
    input logic [7:0]    cause_q,
    input logic [6:0]    mask_q,
    input logic [NW-1:0] post_cnt,
    input logic          post_ok,
    input logic          mask_kill,
    input logic          cause_rd,
    input logic          itv_zero,
    input logic          trigger,
    input logic          any_unm
);
    // R7: every rising edge of the line comes with a counted attempt
    p_rise_counted_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> post_cnt != $past(post_cnt));

    // R5: line only rises with an unmasked cause present
    p_rise_unmasked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> (cause_q[6:0] & mask_q) != 7'd0);

    // R5: counter advances by at most one per cycle
    p_count_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (post_cnt == $past(post_cnt)) || (post_cnt == $past(post_cnt) + 1'b1));

    // R3: zero interval posts an accepted unmasked request immediately
    p_zero_itv_post_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (itv_zero && trigger && any_unm) |=> irq && cause_q[7]);

    // R8: mask clearing all causes drops the line
    p_mask_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mask_kill |=> !irq && !cause_q[7]);

    // R13: read without a new successful post leaves the line low
    p_read_drop_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (cause_rd && !post_ok) |=> !irq);
endmodule

bind intr_moderator imod_checker #(.NW(NW)) u_chk (
    .clk(clk), .rst_n(rst_n), .irq(irq), .cause_q(cause_q), .mask_q(mask_q),
    .post_cnt(post_cnt), .post_ok(post_ok), .mask_kill(mask_kill),
    .cause_rd(cause_rd), .itv_zero(itv_zero), .trigger(trigger), .any_unm(any_unm)
);

// File: tb/intr_moderator_test.sv
module intr_moderator_test;
    localparam int U = 4;
    localparam int D = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] time_now = '0;
    logic        req_valid = 0, req_now = 0, mask_wr = 0, cause_rd = 0;
    logic        rx_done = 0, tx_done = 0;
    logic [6:0]  req_causes = '0, mask_data = '0;
    logic [15:0] itv_cfg = '0, pd_cfg = '0, ab_cfg = '0, tx_cfg = '0;
    logic [15:0] small_thr = '0, rx_len = '0;
    logic        irq;
    logic [7:0]  cause_q;
    logic [15:0] post_cnt;

    int checks = 0, failures = 0;
    bit finished = 0;
    string tag = "R1";

    // behavioural reference state
    logic [6:0]  m_cause, m_mask;
    logic        m_line, m_th, m_pd, m_ab, m_tx;
    logic [31:0] m_thdl, m_pddl, m_abdl, m_txdl, m_last;
    logic [15:0] m_cnt;

    intr_moderator uut (
        .clk(clk), .rst_n(rst_n), .time_now(time_now), .req_valid(req_valid),
        .req_now(req_now), .req_causes(req_causes), .mask_wr(mask_wr),
        .mask_data(mask_data), .cause_rd(cause_rd), .itv_cfg(itv_cfg),
        .pd_cfg(pd_cfg), .ab_cfg(ab_cfg), .tx_cfg(tx_cfg), .small_thr(small_thr),
        .rx_done(rx_done), .rx_len(rx_len), .tx_done(tx_done),
        .irq(irq), .cause_q(cause_q), .post_cnt(post_cnt)
    );

    always #5 clk = ~clk;

    function automatic bit reached(input logic [31:0] now, input logic [31:0] dl);
        logic [31:0] d;
        d = now - dl;
        return !d[31];
    endfunction

    task automatic model_reset();
        m_cause = '0; m_mask = '0; m_line = 0; m_th = 0; m_pd = 0; m_ab = 0; m_tx = 0;
        m_thdl = '0; m_pddl = '0; m_abdl = '0; m_txdl = '0; m_last = '0; m_cnt = '0;
    endtask

    task automatic model_step();
        logic [6:0]  c, mk, r;
        logic        line, imm, trig, post, thd, pdd, abd, txd;
        logic        th_live, pd_live, ab_live, tx_live;
        logic [31:0] span;
        span = 32'(itv_cfg) * U;
        mk   = mask_wr ? mask_data : m_mask;
        c    = cause_rd ? 7'd0 : m_cause;
        line = cause_rd ? 1'b0 : m_line;
        thd = m_th && reached(time_now, m_thdl);
        pdd = m_pd && reached(time_now, m_pddl);
        abd = m_ab && reached(time_now, m_abdl);
        txd = m_tx && reached(time_now, m_txdl);
        r = '0;
        if (pdd || abd) r[1] = 1;
        if (txd) r[0] = 1;
        if (rx_done && pd_cfg == 0 && ab_cfg == 0) r[1] = 1;
        if (rx_done && rx_len <= small_thr) r[2] = 1;
        if (tx_done && tx_cfg == 0) r[0] = 1;
        if (req_valid) r = r | req_causes;
        imm  = req_valid && req_now;
        trig = (r != 0) && (imm || (r & ~c) != 0);
        c    = c | r;
        post = 0;
        th_live = m_th && !thd;
        if (trig) begin
            if (itv_cfg == 0 || imm || reached(time_now, m_last + span)) post = 1;
            else if (!th_live) begin th_live = 1; m_thdl = m_last + span; end
        end
        if (thd) post = 1;
        if (mask_wr) begin
            if ((c & mk) == 0) begin th_live = 0; line = 0; end
            else if (itv_cfg == 0) post = 1;
            else if (!th_live) begin th_live = 1; m_thdl = time_now + span; end
        end
        pd_live = m_pd && !pdd;
        ab_live = m_ab && !abd;
        tx_live = m_tx && !txd;
        if (rx_done && pd_cfg != 0) begin pd_live = 1; m_pddl = time_now + 32'(pd_cfg) * D; end
        if (rx_done && ab_cfg != 0 && !ab_live) begin ab_live = 1; m_abdl = time_now + 32'(ab_cfg) * D; end
        if (tx_done && tx_cfg != 0) begin tx_live = 1; m_txdl = time_now + 32'(tx_cfg) * D; end
        if (post) begin
            m_cnt = m_cnt + 1;
            if ((c & mk) != 0) begin
                th_live = 0;
                if (pd_live || ab_live) c[1] = 1;
                if (tx_live) c[0] = 1;
                pd_live = 0; ab_live = 0; tx_live = 0;
                line = 1;
                m_last = time_now;
            end
        end
        m_cause = c; m_mask = mk; m_line = line; m_th = th_live;
        m_pd = pd_live; m_ab = ab_live; m_tx = tx_live;
    endtask

    task automatic chk(input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h t=%0d", tag, what, act, exp, time_now);
        end
    endtask

    task automatic step();
        if (rst_n) model_step(); else model_reset();
        @(posedge clk);
        @(negedge clk);
        chk("irq", int'(irq), int'(m_line));
        chk("cause", int'(cause_q), int'({m_line, m_cause}));
        chk("count", int'(post_cnt), int'(m_cnt));
        req_valid = 0; req_now = 0; mask_wr = 0; cause_rd = 0; rx_done = 0; tx_done = 0;
        time_now = time_now + 1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic request(input logic [6:0] bits, input logic now_f);
        req_valid = 1; req_causes = bits; req_now = now_f; step();
    endtask

    task automatic set_mask(input logic [6:0] m);
        mask_wr = 1; mask_data = m; step();
    endtask

    task automatic rd();
        cause_rd = 1; step();
    endtask

    task automatic rx(input int len);
        rx_done = 1; rx_len = 16'(len); step();
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        model_reset();
        @(negedge clk);
        idle(3);
        rst_n = 1;
        tag = "R1"; idle(2);
        tag = "R9"; set_mask(7'h7F); idle(1);
        tag = "R3"; request(7'h08, 0); idle(2);
        tag = "R2"; request(7'h08, 0); idle(1);
        request(7'h08, 1); idle(1);
        request(7'h10, 0); idle(1);
        tag = "R13"; rd(); idle(1);
        req_valid = 1; req_causes = 7'h20; cause_rd = 1; step(); idle(1);
        rd();
        tag = "R4"; itv_cfg = 3; request(7'h08, 0); idle(3);
        request(7'h10, 0); idle(15);
        rd(); request(7'h20, 0); idle(2); rd(); request(7'h04, 1); idle(2);
        tag = "R8"; set_mask(7'h00); idle(2);
        tag = "R5"; itv_cfg = 0; rd(); request(7'h08, 0); idle(2);
        tag = "R9"; set_mask(7'h08); idle(2); rd();
        itv_cfg = 2; set_mask(7'h00); request(7'h40, 0); set_mask(7'h40); idle(12);
        tag = "R8"; itv_cfg = 5; rd(); request(7'h40, 0); set_mask(7'h01); idle(25);
        tag = "R10"; itv_cfg = 0; set_mask(7'h7F); rd(); small_thr = 64;
        pd_cfg = 3; rx(100); idle(2); rx(100); idle(10); rd();
        pd_cfg = 0; ab_cfg = 5; rx(100); idle(3); rx(100); idle(10); rd();
        ab_cfg = 0; rx(100); idle(2); rd();
        tag = "R11"; rx(64); idle(1); rd(); rx(65); idle(1); rd(); rx(0); idle(1); rd();
        tag = "R6"; itv_cfg = 5; idle(25); pd_cfg = 20; ab_cfg = 30; tx_cfg = 25; rx(100);
        tx_done = 1; step(); idle(3); request(7'h08, 1); idle(70); rd();
        tag = "R12"; itv_cfg = 0; pd_cfg = 0; ab_cfg = 0; tx_cfg = 3;
        tx_done = 1; step(); idle(2); tx_done = 1; step(); idle(10); rd();
        tx_cfg = 0; tx_done = 1; step(); idle(2); rd();
        tag = "R7"; itv_cfg = 1; request(7'h02, 0); idle(6); rd();
        tag = "R4";
        for (int i = 0; i < 600; i++) begin
            if ($urandom_range(99) < 15) begin
                req_valid = 1; req_causes = 7'($urandom_range(127, 1));
                req_now = ($urandom_range(3) == 0);
            end
            if ($urandom_range(99) < 5) begin mask_wr = 1; mask_data = 7'($urandom_range(127)); end
            if ($urandom_range(99) < 8) cause_rd = 1;
            if ($urandom_range(99) < 10) begin rx_done = 1; rx_len = 16'($urandom_range(127)); end
            if ($urandom_range(99) < 6) tx_done = 1;
            if ($urandom_range(99) < 3) begin
                itv_cfg = 16'($urandom_range(3)); pd_cfg = 16'($urandom_range(4));
                ab_cfg = 16'($urandom_range(6)); tx_cfg = 16'($urandom_range(4));
            end
            step();
        end
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule